// File: doc/BRIEF.md
# PCI Inbound Memory Window Translator

This block holds a small 32-bit control register file and uses part of it to turn host-side accesses into PCI memory addresses. Three memory windows each cover a fixed-size region on the host side. Each window has its own programmable map register, and that register sets where the window lands in a 32-bit PCI memory space. A host access names a window index and a byte offset inside that window. The block then returns the PCI address at once, or reports that the access falls outside the window.

The register file has eight 32-bit words: three window map words, a self-identifier word, a flags word and three secondary map words. Only the window map words affect translation. A build-time parameter selects one of two variants. Variant 0 places the low nibble of a map word in PCI address bits 31:28. Variant 1 keeps the map word's bits above the window size and clears the bits below it. The two variants also use different window sizes. Generating bus transactions is outside this block.

Top module: `pwx_win_xlate`

## Requirements
- R1: After reset every one of the eight register words reads back as zero, so every window base is zero.
- R2: A 32-bit write (`reg_size` = 2) to one of the eight word offsets is stored and read back in the next cycle. The offsets are: window map words 0, 1 and 2 at 0x00, 0x04 and 0x08; self-identifier at 0x0C; flags at 0x10; secondary map words 0, 1 and 2 at 0x14, 0x18 and 0x1C.
- R3: A read from any other offset returns zero. A write to any other offset changes no register. In both cases `reg_err` is high in the same cycle. Unaligned offsets and offsets of 0x20 and above count as other offsets.
- R4: An access whose `reg_size` is not 2 (1, 2 or 8 bytes) reads zero, writes nothing and raises `reg_err`.
- R5: In variant 0 the base of window w is map word w shifted left by 28 bits, so only the low 4 bits of the word are used.
- R6: In variant 1 the base of window w is map word w ANDed with the inverse of (size of window w − 1).
- R7: Variant 0 uses window sizes 0x0C000000, 0x10000000 and 0x10000000. Variant 1 uses 0x01000000, 0x04000000 and 0x08000000. The order is window 0, 1, 2.
- R8: When `xl_req` is high, `xl_win` is 0..2 and `xl_off` is below that window's size, `xl_valid` is high and `xl_addr` = (base + offset) mod 2^32, in the same cycle.
- R9: When `xl_req` is high and the offset is at or above the window size, or `xl_win` is 3, `xl_range_err` is high, `xl_valid` is low and `xl_addr` is zero. With `xl_req` low, both flags are low.
- R10: A write to a window map word changes that window's translation from the cycle after the write. In the cycle of the write, the old mapping still applies.
- R11: Writes to the self-identifier, flags and secondary map words leave every translation unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_size | input | 2 | Access size as log2 of bytes; 2 is the only legal value |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational, zero when no legal read |
| reg_err | output | 1 | Illegal offset or size on the current access |
| xl_req | input | 1 | Translation request |
| xl_win | input | 2 | Window index |
| xl_off | input | 32 | Byte offset inside the window |
| xl_addr | output | 32 | Translated PCI address |
| xl_valid | output | 1 | Translation is in range |
| xl_range_err | output | 1 | Offset or window index out of range |

## Verification
Read data, the error flag and every translation output are combinational. The bench drives them on the falling edge and samples them a short delay later in the same half cycle. A register write is captured on the following rising edge, so its effect on read-back and on translation is due one cycle later. The bench therefore checks translation once in the write cycle, where it must still show the old base, and once more after the edge. The internal reset release takes two rising edges, so the bench waits several cycles before its first access. Both variants run side by side, and the bench sweeps every window, including the invalid index 3, over a set of map patterns and offsets placed at and around the window boundaries.

// File: rtl/pwx_pkg.sv
package pwx_pkg;

  localparam int DATA_W    = 32;
  localparam int REG_AW    = 12;
  localparam int WIN_N     = 3;
  localparam int WIN_IDX_W = 2;
  localparam int NIB_W     = 4;
  localparam logic [1:0] SIZE_WORD = 2'd2;

  // window size per variant and window index
  function automatic logic [DATA_W-1:0] win_size(input int variant, input int idx);
    logic [DATA_W-1:0] s;
    if (variant == 0) begin
      case (idx)
        0:       s = 32'h0C00_0000;
        default: s = 32'h1000_0000;
      endcase
    end else begin
      case (idx)
        0:       s = 32'h0100_0000;
        1:       s = 32'h0400_0000;
        default: s = 32'h0800_0000;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/pwx_rst_sync.sv
module pwx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/pwx_regfile.sv
module pwx_regfile
  import pwx_pkg::*;
#(
  parameter int AW   = REG_AW,
  parameter int DW   = DATA_W,
  parameter int NWIN = WIN_N
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic                     rd,
  input  logic [AW-1:0]            addr,
  input  logic [1:0]               size,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata,
  output logic                     err,
  output logic [NWIN-1:0][DW-1:0]  map_o
);

  localparam int NREG   = 2 * NWIN + 2;
  localparam int IDXW   = $clog2(NREG);
  localparam int SELF_I = NWIN;
  localparam int FLG_I  = NWIN + 1;
  localparam int SEC_I  = NWIN + 2;

  logic [NWIN-1:0][DW-1:0] map_q, map_d;
  logic [NWIN-1:0][DW-1:0] sec_q, sec_d;
  logic [DW-1:0]           self_q, self_d;
  logic [DW-1:0]           flg_q, flg_d;

  logic [IDXW-1:0] idx;
  logic            aligned, hi_zero, idx_ok, size_ok, hit, we;

  // decode
  always_comb begin
    idx     = addr[IDXW+1:2];
    aligned = (addr[1:0] == 2'b00);
    hi_zero = (addr[AW-1:IDXW+2] == '0);
    idx_ok  = (int'(idx) < NREG);
    size_ok = (size == SIZE_WORD);
    hit     = aligned && hi_zero && idx_ok && size_ok;
    err     = (wr || rd) && !hit;
    we      = wr && hit;
  end

  // next state
  always_comb begin
    map_d  = map_q;
    sec_d  = sec_q;
    self_d = self_q;
    flg_d  = flg_q;
    for (int i = 0; i < NWIN; i++) begin
      if (int'(idx) == i)         map_d[i] = wdata;
      if (int'(idx) == SEC_I + i) sec_d[i] = wdata;
    end
    if (int'(idx) == SELF_I) self_d = wdata;
    if (int'(idx) == FLG_I)  flg_d  = wdata;
  end

  // state registers with write enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q  <= '0;
      sec_q  <= '0;
      self_q <= '0;
      flg_q  <= '0;
    end else if (we) begin
      map_q  <= map_d;
      sec_q  <= sec_d;
      self_q <= self_d;
      flg_q  <= flg_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (rd && hit) begin
      for (int i = 0; i < NWIN; i++) begin
        if (int'(idx) == i)         rdata = map_q[i];
        if (int'(idx) == SEC_I + i) rdata = sec_q[i];
      end
      if (int'(idx) == SELF_I) rdata = self_q;
      if (int'(idx) == FLG_I)  rdata = flg_q;
    end
  end

  assign map_o = map_q;

endmodule

// File: rtl/pwx_base_calc.sv
module pwx_base_calc
  import pwx_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int DW      = DATA_W,
  parameter int NWIN    = WIN_N
) (
  input  logic [NWIN-1:0][DW-1:0] map_i,
  output logic [NWIN-1:0][DW-1:0] base_o,
  output logic [NWIN-1:0][DW-1:0] size_o
);

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam logic [DW-1:0] SZ = win_size(VARIANT, g);
    if (VARIANT == 0) begin : g_nib
      assign base_o[g] = {map_i[g][NIB_W-1:0], {(DW-NIB_W){1'b0}}};
    end else begin : g_msk
      assign base_o[g] = map_i[g] & ~(SZ - 1'b1);
    end
    assign size_o[g] = SZ;
  end

endmodule

// File: rtl/pwx_xlate.sv
module pwx_xlate
  import pwx_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int NWIN = WIN_N,
  parameter int WINW = WIN_IDX_W
) (
  input  logic                    req,
  input  logic [WINW-1:0]         win,
  input  logic [DW-1:0]           off,
  input  logic [NWIN-1:0][DW-1:0] base_i,
  input  logic [NWIN-1:0][DW-1:0] size_i,
  output logic [DW-1:0]           addr,
  output logic                    valid,
  output logic                    range_err
);

  logic [DW-1:0] sel_base, sel_size;
  logic          win_ok, in_rng;

  always_comb begin
    sel_base = '0;
    sel_size = '0;
    win_ok   = 1'b0;
    for (int i = 0; i < NWIN; i++) begin
      if (int'(win) == i) begin
        sel_base = base_i[i];
        sel_size = size_i[i];
        win_ok   = 1'b1;
      end
    end
    in_rng    = win_ok && (off < sel_size);
    valid     = req && in_rng;
    range_err = req && !in_rng;
    addr      = valid ? (sel_base + off) : '0;
  end

endmodule

// File: rtl/pwx_win_xlate.sv
module pwx_win_xlate
  import pwx_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int AW      = REG_AW,
  parameter int DW      = DATA_W,
  parameter int NWIN    = WIN_N,
  parameter int WINW    = WIN_IDX_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [AW-1:0]   reg_addr,
  input  logic [1:0]      reg_size,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            reg_err,
  input  logic            xl_req,
  input  logic [WINW-1:0] xl_win,
  input  logic [DW-1:0]   xl_off,
  output logic [DW-1:0]   xl_addr,
  output logic            xl_valid,
  output logic            xl_range_err
);

  logic                    rst_n_i;
  logic [NWIN-1:0][DW-1:0] map_w, base_w, size_w;

  pwx_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_i)
  );

  pwx_regfile #(.AW(AW), .DW(DW), .NWIN(NWIN)) u_regs (
    .clk   (clk),
    .rst_n (rst_n_i),
    .wr    (reg_wr),
    .rd    (reg_rd),
    .addr  (reg_addr),
    .size  (reg_size),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .err   (reg_err),
    .map_o (map_w)
  );

  pwx_base_calc #(.VARIANT(VARIANT), .DW(DW), .NWIN(NWIN)) u_base (
    .map_i  (map_w),
    .base_o (base_w),
    .size_o (size_w)
  );

  pwx_xlate #(.DW(DW), .NWIN(NWIN), .WINW(WINW)) u_xl (
    .req       (xl_req),
    .win       (xl_win),
    .off       (xl_off),
    .base_i    (base_w),
    .size_i    (size_w),
    .addr      (xl_addr),
    .valid     (xl_valid),
    .range_err (xl_range_err)
  );

endmodule

// File: rtl/pwx_win_xlate_chk.sv
module pwx_win_xlate_chk
  import pwx_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int AW      = REG_AW,
  parameter int DW      = DATA_W,
  parameter int NWIN    = WIN_N,
  parameter int WINW    = WIN_IDX_W
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_wr,
  input logic                    reg_rd,
  input logic [AW-1:0]           reg_addr,
  input logic                    reg_err,
  input logic [DW-1:0]           reg_rdata,
  input logic                    xl_req,
  input logic [WINW-1:0]         xl_win,
  input logic [DW-1:0]           xl_off,
  input logic                    xl_valid,
  input logic                    xl_range_err,
  input logic [NWIN-1:0][DW-1:0] map_w
);

  logic [DW-1:0] chk_size;
  logic          map_addr;

  always_comb begin
    chk_size = '0;
    for (int i = 0; i < NWIN; i++)
      if (int'(xl_win) == i) chk_size = win_size(VARIANT, i);
    map_addr = (int'(reg_addr) < 4 * NWIN);
  end

  // R3: a rejected read yields zero data
  p_bad_rd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_err) |-> (reg_rdata == '0));

  // R4: a rejected write leaves the map words alone
  p_bad_wr_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_err) |=> $stable(map_w));

  // R11: legal writes outside the map words leave them alone
  p_other_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_err && !map_addr) |=> $stable(map_w));

  // R8: a valid translation always has its offset inside the window
  p_inrange_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid |-> (xl_off < chk_size));

  // R9: valid and range error never together; both idle without request
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(xl_valid && xl_range_err));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_req |-> (!xl_valid && !xl_range_err));

endmodule

bind pwx_win_xlate pwx_win_xlate_chk #(
  .VARIANT(VARIANT), .AW(AW), .DW(DW), .NWIN(NWIN), .WINW(WINW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_rd       (reg_rd),
  .reg_addr     (reg_addr),
  .reg_err      (reg_err),
  .reg_rdata    (reg_rdata),
  .xl_req       (xl_req),
  .xl_win       (xl_win),
  .xl_off       (xl_off),
  .xl_valid     (xl_valid),
  .xl_range_err (xl_range_err),
  .map_w        (map_w)
);

// File: tb/tb_pwx_win_xlate.sv
module tb_pwx_win_xlate;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [1:0]  reg_size = 2'd2;
  logic [31:0] reg_wdata = '0;
  logic        xl_req = 1'b0;
  logic [1:0]  xl_win = '0;
  logic [31:0] xl_off = '0;

  logic [31:0] rdata0, rdata1, addr0, addr1;
  logic        err0, err1, v0, v1, re0, re1;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] mdl [8];

  always #(PERIOD/2) clk = ~clk;

  pwx_win_xlate #(.VARIANT(0)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
    .reg_rdata(rdata0), .reg_err(err0), .xl_req(xl_req), .xl_win(xl_win),
    .xl_off(xl_off), .xl_addr(addr0), .xl_valid(v0), .xl_range_err(re0));

  pwx_win_xlate #(.VARIANT(1)) dut_v1 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
    .reg_rdata(rdata1), .reg_err(err1), .xl_req(xl_req), .xl_win(xl_win),
    .xl_off(xl_off), .xl_addr(addr1), .xl_valid(v1), .xl_range_err(re1));

  function automatic logic [31:0] e_size(int var_i, int w);
    if (var_i == 0) return (w == 0) ? 32'h0C00_0000 : 32'h1000_0000;
    case (w)
      0: return 32'h0100_0000;
      1: return 32'h0400_0000;
      default: return 32'h0800_0000;
    endcase
  endfunction

  function automatic logic [31:0] e_base(int var_i, int w, logic [31:0] m);
    if (var_i == 0) return m << 28;
    return m & ~(e_size(var_i, w) - 32'd1);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [11:0] a, logic [31:0] d, logic [1:0] sz);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_size = sz;
    @(negedge clk);
    reg_wr = 1'b0; reg_size = 2'd2;
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [1:0] sz,
                        logic [31:0] exp, logic exp_err);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a; reg_size = sz;
    #1;
    chk({tag, " rdata v0"}, rdata0, exp);
    chk({tag, " rdata v1"}, rdata1, exp);
    chk({tag, " err"}, {30'b0, err1, err0}, {30'b0, exp_err, exp_err});
    reg_rd = 1'b0; reg_size = 2'd2;
  endtask

  // translation check on both variants at current time (inputs held)
  task automatic xl_now(string tag, int w);
    logic [31:0] ea, sz, bs;
    logic ev;
    for (int vi = 0; vi < 2; vi++) begin
      sz = (w < 3) ? e_size(vi, w) : 32'd0;
      bs = (w < 3) ? e_base(vi, w, mdl[w]) : 32'd0;
      ev = (w < 3) && (xl_off < sz);
      ea = ev ? bs + xl_off : 32'd0;
      chk($sformatf("%s win%0d off %h var%0d addr", tag, w, xl_off, vi),
          vi == 0 ? addr0 : addr1, ea);
      chk($sformatf("%s win%0d var%0d flags", tag, w, vi),
          {30'b0, (vi == 0 ? v0 : v1), (vi == 0 ? re0 : re1)},
          {30'b0, ev, ~ev});
    end
  endtask

  task automatic xl_chk(string tag, int w, logic [31:0] off);
    @(negedge clk);
    xl_req = 1'b1; xl_win = w[1:0]; xl_off = off;
    #1;
    xl_now(tag, w);
    xl_req = 1'b0;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [6];
    logic [31:0] offs [7];
    pats = '{32'h0, 32'hFFFF_FFFF, 32'h1234_5678, 32'hA5A5_A5A5, 32'h0000_000F, 32'h0A00_0007};
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int i = 0; i < 8; i++) rd_chk("R1 reset", 12'(4 * i), 2'd2, 32'h0, 1'b0);
    xl_chk("R1 base", 0, 32'h0000_0100);

    // idle request: flags low
    @(negedge clk); #1;
    chk("R9 idle", {30'b0, v0 | v1, re0 | re1}, 32'h0);

    // R2: write and read back all words
    for (int i = 0; i < 8; i++) begin
      mdl[i] = 32'h1111_1111 * (i + 1) ^ 32'h8000_0005;
      wr_reg(12'(4 * i), mdl[i], 2'd2);
    end
    for (int i = 0; i < 8; i++) rd_chk("R2 readback", 12'(4 * i), 2'd2, mdl[i], 1'b0);

    // R3: unmapped offsets
    rd_chk("R3 rd 0x20", 12'h020, 2'd2, 32'h0, 1'b1);
    rd_chk("R3 rd 0x402", 12'h402, 2'd2, 32'h0, 1'b1);
    rd_chk("R3 rd unaligned", 12'h005, 2'd2, 32'h0, 1'b1);
    wr_reg(12'h020, 32'hDEAD_BEEF, 2'd2);
    wr_reg(12'h001, 32'hDEAD_BEEF, 2'd2);
    wr_reg(12'hFFC, 32'hDEAD_BEEF, 2'd2);
    for (int i = 0; i < 8; i++) rd_chk("R3 unchanged", 12'(4 * i), 2'd2, mdl[i], 1'b0);

    // R4: wrong sizes
    for (int s = 0; s < 4; s++) begin
      if (s == 2) continue;
      rd_chk("R4 rd size", 12'h000, 2'(s), 32'h0, 1'b1);
      wr_reg(12'h000, 32'hCAFE_0000, 2'(s));
      wr_reg(12'h00C, 32'hCAFE_0000, 2'(s));
    end
    rd_chk("R4 map0 kept", 12'h000, 2'd2, mdl[0], 1'b0);
    rd_chk("R4 self kept", 12'h00C, 2'd2, mdl[3], 1'b0);

    // R5 R6 R7 R8 R9: sweep patterns, windows, boundary offsets
    for (int p = 0; p < 6; p++) begin
      for (int w = 0; w < 3; w++) begin
        mdl[w] = pats[p] ^ (32'h0100_0001 * w);
        wr_reg(12'(4 * w), mdl[w], 2'd2);
      end
      for (int w = 0; w < 4; w++) begin
        for (int vi = 0; vi < 2; vi++) begin
          logic [31:0] sz;
          sz = (w < 3) ? e_size(vi, w) : 32'h1000;
          offs = '{32'h0, 32'h1, sz - 32'd1, sz, sz + 32'd4, 32'hFFFF_FFFF, sz >> 1};
          for (int o = 0; o < 7; o++) xl_chk("R5 R6 R7 R8 R9 sweep", w, offs[o]);
        end
      end
    end

    // R10: same-cycle write keeps old mapping, next cycle uses new
    @(negedge clk);
    xl_req = 1'b1; xl_win = 2'd1; xl_off = 32'h0000_0040;
    reg_wr = 1'b1; reg_addr = 12'h004; reg_wdata = 32'h0F00_0003; reg_size = 2'd2;
    #1;
    xl_now("R10 old", 1);
    @(negedge clk);
    reg_wr = 1'b0;
    mdl[1] = 32'h0F00_0003;
    #1;
    xl_now("R10 new", 1);
    xl_req = 1'b0;

    // R11: other registers do not disturb translation
    wr_reg(12'h00C, 32'hFFFF_FFFF, 2'd2);
    wr_reg(12'h010, 32'hFFFF_FFFF, 2'd2);
    wr_reg(12'h014, 32'hFFFF_FFFF, 2'd2);
    wr_reg(12'h018, 32'hFFFF_FFFF, 2'd2);
    wr_reg(12'h01C, 32'hFFFF_FFFF, 2'd2);
    for (int w = 0; w < 3; w++) xl_chk("R11 unchanged", w, 32'h0000_1234);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule